// File: doc/BRIEF.md
# Transmit Packet Header Inserter

This block prepares outgoing packets for a serial-bus link packetizer. Payload quadlets are written into an internal transmit FIFO either from a bulk DMA stream or from two host register strobes, and a sequencer drains that FIFO onto a quadlet output stream that carries start and end markers.

Two framing modes exist. With the insert mode bit set, the FIFO holds only payload, and the block emits four header quadlets from host-programmed header registers ahead of it. With the insert mode bit clear, the FIFO already holds complete formatted packets, and they pass through unchanged. The mode and the header words are captured when a packet starts, so host writes made during a packet do not affect it. A self-clearing clear bit empties the FIFO and abandons any packet in progress.

Both streams use valid/ready handshakes. A beat moves on a rising edge where valid and ready are both high. A source that raises valid holds it, and the beat with it, until the beat is taken. The block never withdraws an output beat while it is stalled, except when a clear empties the FIFO. The DMA input sees ready low whenever the FIFO is full or the DMA port is not the selected source.

Top module: `tx_hdr_inserter`

## Requirements
- R1: With cfg_insert=1 at packet start, the output carries hdr_regs[31:0], [63:32], [95:64] and [127:96] in that order, with out_sop=1 only on the first of them. The packet's payload quadlets follow in FIFO order, and out_eop=1 on the payload quadlet written as last.
- R2: With cfg_insert=0 at packet start, FIFO quadlets are forwarded unchanged. out_sop=1 on the first quadlet of the packet and out_eop=1 on the quadlet written as last.
- R3: With cfg_src_dma=1, a DMA beat is written to the FIFO on each handshake, and dma_last=1 marks the final quadlet of a packet.
- R4: With cfg_src_dma=0, a pulse on reg_wr_first writes reg_wdata as a non-last quadlet, and a pulse on reg_wr_update writes it as the last quadlet of a packet.
- R5: The source that is not selected is ignored. dma_ready stays 0 while cfg_src_dma=0, and register strobes write nothing while cfg_src_dma=1.
- R6: While out_valid=1 and out_ready=0, the next cycle still has out_valid=1 with out_data, out_sop and out_eop unchanged, unless a clear is requested.
- R7: The header words and the mode are captured when a packet starts. Changes to hdr_regs or cfg_insert after that point do not alter the packet.
- R8: A cycle with clr_req=1 empties the FIFO and returns the sequencer to idle, so out_valid is 0 in the following cycle. A write in the same cycle as the clear is discarded.
- R9: clr_stat reads 1 for exactly the one cycle after clr_req is sampled and 0 otherwise.
- R10: After reset, out_valid=0, clr_stat=0, and dma_ready equals cfg_src_dma.
- R11: dma_ready is 0 while the FIFO holds DEPTH quadlets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_insert | input | 1 | 1: prepend header words; 0: forward complete packets |
| cfg_src_dma | input | 1 | 1: FIFO fed from DMA port; 0: from register strobes |
| clr_req | input | 1 | Write of 1 to the clear bit |
| clr_stat | output | 1 | Read-back of the self-clearing clear bit |
| hdr_regs | input | 4*DW | Header words, word k at bits [32k+31:32k] |
| dma_valid | input | 1 | DMA beat valid |
| dma_ready | output | 1 | DMA beat accepted |
| dma_data | input | DW | DMA payload quadlet |
| dma_last | input | 1 | DMA quadlet ends a packet |
| reg_wr_first | input | 1 | Register write of a non-last quadlet |
| reg_wr_update | input | 1 | Register write of a last quadlet |
| reg_wdata | input | DW | Register write data |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat accepted |
| out_data | output | DW | Output quadlet |
| out_sop | output | 1 | First quadlet of a packet |
| out_eop | output | 1 | Last quadlet of a packet |

## Verification
A FIFO write lands at one edge. The sequencer leaves idle at the next edge, and the first beat of the packet (header 0 or the first raw quadlet) is valid from then on. Each later beat can move on every edge where out_ready is high. Because the output is throttled by a random out_ready, the bench compares accepted beats in order against a queue of expected beats, sampling at the falling edge, instead of fixing a latency for the stream. Clear and reset results have a fixed timing: out_valid=0 and clr_stat=1 in the cycle after clr_req is sampled, and clr_stat=0 one cycle later. The bench samples exactly those cycles.

// File: rtl/txh_pkg.sv
package txh_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_HDR  = 2'd1,
    S_PAY  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/txh_fifo.sv
module txh_fifo #(
  parameter int W     = 33,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_ptr, rd_ptr;
  logic         do_wr, do_rd;

  assign empty   = (wr_ptr == rd_ptr);
  assign full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign do_wr   = wr_en && !full && !clr;
  assign do_rd   = rd_en && !empty && !clr;
  assign rd_data = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (do_wr) wr_ptr <= wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/txh_src_sel.sv
module txh_src_sel #(
  parameter int DW = 32
) (
  input  logic          sel_dma,
  input  logic          clr,
  input  logic          fifo_full,
  input  logic          dma_valid,
  input  logic [DW-1:0] dma_data,
  input  logic          dma_last,
  output logic          dma_ready,
  input  logic          reg_wr_first,
  input  logic          reg_wr_update,
  input  logic [DW-1:0] reg_wdata,
  output logic          push,
  output logic [DW:0]   push_word
);
  logic room;
  assign room      = !fifo_full && !clr;
  assign dma_ready = sel_dma && room;

  always_comb begin
    push      = 1'b0;
    push_word = '0;
    if (sel_dma) begin
      push      = dma_valid && room;
      push_word = {dma_last, dma_data};
    end else begin
      push      = (reg_wr_first || reg_wr_update) && room;
      push_word = {reg_wr_update, reg_wdata};
    end
  end
endmodule

// File: rtl/txh_seq.sv
module txh_seq
  import txh_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NHDR = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             insert_mode,
  input  logic [NHDR*DW-1:0] hdr_regs,
  input  logic             fifo_empty,
  input  logic [DW-1:0]    head_data,
  input  logic             head_last,
  output logic             pop,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic             out_sop,
  output logic             out_eop
);
  localparam int IW = (NHDR > 1) ? $clog2(NHDR) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(NHDR - 1);

  seq_state_e    st;
  logic [IW-1:0] idx;
  logic          ins_q;
  logic          first_q;
  logic [DW-1:0] hdr_lat [NHDR];

  always_comb begin
    out_valid = 1'b0;
    out_data  = '0;
    out_sop   = 1'b0;
    out_eop   = 1'b0;
    pop       = 1'b0;
    case (st)
      S_HDR: begin
        out_valid = 1'b1;
        out_data  = hdr_lat[idx];
        out_sop   = (idx == '0);
      end
      S_PAY: begin
        out_valid = !fifo_empty;
        out_data  = head_data;
        out_sop   = first_q && !ins_q;
        out_eop   = head_last;
        pop       = !fifo_empty && out_ready;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      idx     <= '0;
      ins_q   <= 1'b0;
      first_q <= 1'b0;
      for (int i = 0; i < NHDR; i++) hdr_lat[i] <= '0;
    end else if (clr) begin
      st      <= S_IDLE;
      idx     <= '0;
      first_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (!fifo_empty) begin
            ins_q   <= insert_mode;
            first_q <= 1'b1;
            idx     <= '0;
            for (int i = 0; i < NHDR; i++) hdr_lat[i] <= hdr_regs[i*DW +: DW];
            st      <= insert_mode ? S_HDR : S_PAY;
          end
        end
        S_HDR: begin
          if (out_ready) begin
            if (idx == LAST_IDX) st <= S_PAY;
            else idx <= idx + 1'b1;
          end
        end
        S_PAY: begin
          if (!fifo_empty && out_ready) begin
            first_q <= 1'b0;
            if (head_last) st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_hdr_inserter.sv
module tx_hdr_inserter #(
  parameter int DW    = 32,
  parameter int NHDR  = 4,
  parameter int DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_insert,
  input  logic               cfg_src_dma,
  input  logic               clr_req,
  output logic               clr_stat,
  input  logic [NHDR*DW-1:0] hdr_regs,
  input  logic               dma_valid,
  output logic               dma_ready,
  input  logic [DW-1:0]      dma_data,
  input  logic               dma_last,
  input  logic               reg_wr_first,
  input  logic               reg_wr_update,
  input  logic [DW-1:0]      reg_wdata,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DW-1:0]      out_data,
  output logic               out_sop,
  output logic               out_eop
);
  localparam int FW = DW + 1;

  logic          push, pop, f_empty, f_full;
  logic [FW-1:0] push_word, head_word;
  logic          clr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) clr_q <= 1'b0;
    else        clr_q <= clr_req;
  end
  assign clr_stat = clr_q;

  txh_src_sel #(.DW(DW)) u_src (
    .sel_dma      (cfg_src_dma),
    .clr          (clr_req),
    .fifo_full    (f_full),
    .dma_valid    (dma_valid),
    .dma_data     (dma_data),
    .dma_last     (dma_last),
    .dma_ready    (dma_ready),
    .reg_wr_first (reg_wr_first),
    .reg_wr_update(reg_wr_update),
    .reg_wdata    (reg_wdata),
    .push         (push),
    .push_word    (push_word)
  );

  txh_fifo #(.W(FW), .DEPTH(DEPTH)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr_req),
    .wr_en  (push),
    .wr_data(push_word),
    .rd_en  (pop),
    .rd_data(head_word),
    .empty  (f_empty),
    .full   (f_full)
  );

  txh_seq #(.DW(DW), .NHDR(NHDR)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr_req),
    .insert_mode(cfg_insert),
    .hdr_regs   (hdr_regs),
    .fifo_empty (f_empty),
    .head_data  (head_word[DW-1:0]),
    .head_last  (head_word[DW]),
    .pop        (pop),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_sop    (out_sop),
    .out_eop    (out_eop)
  );
endmodule

// File: rtl/txh_chk.sv
module txh_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_req,
  input logic          clr_stat,
  input logic          cfg_src_dma,
  input logic          dma_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_sop,
  input logic          out_eop
);
  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clr_req) |=>
      (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));

  // R8
  clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> !out_valid);

  // R9
  clr_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> clr_stat);

  // R9
  clr_bit_self_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_req |=> !clr_stat);

  // R5
  src_dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_src_dma |-> !dma_ready);
endmodule

bind tx_hdr_inserter txh_chk #(.DW(DW)) u_txh_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr_req    (clr_req),
  .clr_stat   (clr_stat),
  .cfg_src_dma(cfg_src_dma),
  .dma_ready  (dma_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_sop    (out_sop),
  .out_eop    (out_eop)
);

// File: tb/test_tx_hdr_inserter.sv
module test_tx_hdr_inserter;
  localparam int DW = 32;
  localparam int NHDR = 4;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_insert = 1'b0, cfg_src_dma = 1'b1, clr_req = 1'b0, clr_stat;
  logic [NHDR*DW-1:0] hdr_regs = '0;
  logic dma_valid = 1'b0, dma_ready, dma_last = 1'b0;
  logic [DW-1:0] dma_data = '0, reg_wdata = '0, out_data;
  logic reg_wr_first = 1'b0, reg_wr_update = 1'b0;
  logic out_valid, out_ready = 1'b0, out_sop, out_eop;

  tx_hdr_inserter #(.DW(DW), .NHDR(NHDR), .DEPTH(DEPTH)) i_tx_hdr_inserter (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, n_beats = 0;
  int rdy_mode = 1;  // 0 random, 1 low, 2 high
  bit done = 0;
  logic [DW+1:0] exp_q[$];
  string tag_q[$];
  logic prev_stall = 0;
  logic [DW+1:0] prev_beat = '0;

  function automatic logic [DW+1:0] mk(input logic sop, input logic eop, input logic [DW-1:0] d);
    return {sop, eop, d};
  endfunction

  task automatic check(input string req, input logic [DW+1:0] act, input logic [DW+1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    case (rdy_mode)
      0: out_ready = ($urandom % 4) != 0;
      1: out_ready = 1'b0;
      default: out_ready = 1'b1;
    endcase
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall && out_valid)
        check("R6", mk(out_sop, out_eop, out_data), prev_beat);
      if (out_valid && out_ready) begin
        n_beats++;
        if (exp_q.size() == 0) check("R8 unexpected beat", mk(out_sop, out_eop, out_data), '0 ^ {(DW+2){1'bx}});
        else check(tag_q.pop_front(), mk(out_sop, out_eop, out_data), exp_q.pop_front());
      end
      prev_stall = out_valid && !out_ready;
      prev_beat  = mk(out_sop, out_eop, out_data);
    end
  end

  task automatic push_dma(input logic [DW-1:0] d, input logic last);
    @(posedge clk); #1;
    dma_valid = 1'b1; dma_data = d; dma_last = last;
    forever begin
      @(negedge clk);
      if (dma_ready) break;
    end
    @(posedge clk); #1;
    dma_valid = 1'b0;
  endtask

  task automatic push_reg(input logic [DW-1:0] d, input logic last);
    @(posedge clk); #1;
    reg_wdata = d;
    if (last) reg_wr_update = 1'b1; else reg_wr_first = 1'b1;
    @(posedge clk); #1;
    reg_wr_first = 1'b0; reg_wr_update = 1'b0;
  endtask

  task automatic expect_pkt(input bit ins, input logic [NHDR*DW-1:0] hdr,
                            input logic [DW-1:0] pay[$], input string req);
    if (ins)
      for (int k = 0; k < NHDR; k++) begin
        exp_q.push_back(mk(k == 0, 1'b0, hdr[k*DW +: DW]));
        tag_q.push_back("R1 header");
      end
    for (int k = 0; k < pay.size(); k++) begin
      exp_q.push_back(mk(!ins && k == 0, k == pay.size() - 1, pay[k]));
      tag_q.push_back(req);
    end
  endtask

  task automatic push_pay(input bit dma, input logic [DW-1:0] pay[$]);
    for (int k = 0; k < pay.size(); k++)
      if (dma) push_dma(pay[k], k == pay.size() - 1);
      else     push_reg(pay[k], k == pay.size() - 1);
  endtask

  task automatic drain(input string req);
    int t = 0;
    while (exp_q.size() != 0 && t < 3000) begin
      @(posedge clk); t++;
    end
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL %s actual=%0d beats pending expected=0", req, exp_q.size());
      exp_q.delete(); tag_q.delete();
    end
    repeat (3) @(posedge clk);
  endtask

  task automatic send_pkt(input bit ins, input bit dma, input int len);
    logic [DW-1:0] pay[$];
    logic [NHDR*DW-1:0] hdr;
    string req;
    for (int k = 0; k < NHDR; k++) hdr[k*DW +: DW] = $urandom;
    for (int k = 0; k < len; k++) pay.push_back($urandom);
    req = ins ? (dma ? "R1/R3 payload" : "R1/R4 payload") : (dma ? "R2/R3 raw" : "R2/R4 raw");
    @(posedge clk); #1;
    cfg_insert = ins; cfg_src_dma = dma; hdr_regs = hdr;
    expect_pkt(ins, hdr, pay, req);
    push_pay(dma, pay);
    drain(req);
  endtask

  task automatic quiet_check(input string req, input int beats_before);
    repeat (12) @(posedge clk);
    check(req, 34'(n_beats), 34'(beats_before));
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] pay[$];
    logic [NHDR*DW-1:0] hA, hB;
    int nb;
    void'($urandom(32'h7a11_0c5d));
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 out_valid", 34'(out_valid), 34'(0));
    check("R10 clr_stat", 34'(clr_stat), 34'(0));
    check("R10 dma_ready", 34'(dma_ready), 34'(1));
    rdy_mode = 2;

    // Directed: R1 insert via DMA, R2 raw via registers, single-quadlet raw
    send_pkt(1, 1, 3);
    send_pkt(0, 0, 4);
    send_pkt(0, 1, 1);
    send_pkt(1, 0, 1);

    // R7: mid-packet header and mode changes have no effect
    rdy_mode = 1;
    pay.delete();
    for (int k = 0; k < 3; k++) pay.push_back($urandom);
    for (int k = 0; k < NHDR; k++) begin hA[k*DW +: DW] = $urandom; hB[k*DW +: DW] = ~hA[k*DW +: DW]; end
    @(posedge clk); #1 cfg_insert = 1; cfg_src_dma = 1; hdr_regs = hA;
    for (int k = 0; k < NHDR; k++) begin exp_q.push_back(mk(k == 0, 0, hA[k*DW +: DW])); tag_q.push_back("R7 header"); end
    for (int k = 0; k < 3; k++) begin exp_q.push_back(mk(0, k == 2, pay[k])); tag_q.push_back("R7 payload"); end
    push_pay(1, pay);
    @(posedge clk); #1 hdr_regs = hB; cfg_insert = 0;
    rdy_mode = 0;
    drain("R7");

    // R11: FIFO full drops dma_ready
    rdy_mode = 1;
    @(posedge clk); #1 cfg_insert = 0; cfg_src_dma = 1;
    pay.delete();
    for (int k = 0; k < DEPTH; k++) pay.push_back($urandom);
    expect_pkt(0, '0, pay, "R11 drain");
    push_pay(1, pay);
    @(posedge clk); #1 dma_valid = 1; dma_data = 32'hdead_beef; dma_last = 1;
    repeat (3) @(negedge clk);
    check("R11 dma_ready when full", 34'(dma_ready), 34'(0));
    @(posedge clk); #1 dma_valid = 0;
    rdy_mode = 0;
    drain("R11");

    // R8/R9: clear mid-packet, with a same-cycle register write
    rdy_mode = 1;
    @(posedge clk); #1 cfg_insert = 1; cfg_src_dma = 0;
    push_reg(32'h1111_0001, 0);
    push_reg(32'h1111_0002, 0);
    repeat (2) @(posedge clk);
    #1 clr_req = 1; reg_wdata = 32'h2222_0003; reg_wr_update = 1;
    @(posedge clk); #1 clr_req = 0; reg_wr_update = 0;
    @(negedge clk);
    check("R9 clr_stat after write", 34'(clr_stat), 34'(1));
    check("R8 out_valid after clear", 34'(out_valid), 34'(0));
    @(negedge clk);
    check("R9 clr_stat self-clears", 34'(clr_stat), 34'(0));
    nb = n_beats;
    rdy_mode = 2;
    quiet_check("R8 no beats after clear", nb);
    send_pkt(0, 0, 2);

    // R5: unselected sources are ignored
    @(posedge clk); #1 cfg_src_dma = 0; dma_valid = 1; dma_data = 32'h5555_aaaa; dma_last = 1;
    nb = n_beats;
    @(negedge clk);
    check("R5 dma_ready with register source", 34'(dma_ready), 34'(0));
    repeat (4) @(posedge clk);
    #1 dma_valid = 0; cfg_src_dma = 1;
    push_reg(32'h7777_0001, 1);
    quiet_check("R5 ignored sources write nothing", nb);

    // Random phase
    rdy_mode = 0;
    for (int p = 0; p < 40; p++)
      send_pkt($urandom % 2, $urandom % 2, 1 + ($urandom % 8));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule